// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesis Core

This core produces a 10-bit digital amplitude stream for an external DAC. A 32-bit phase accumulator advances every clock by a frequency tuning word. A signed frequency-modulation offset is added to that word. The upper 12 bits of the accumulator form the working phase, and a phase-modulation offset is added to it before any waveform is formed.

From that one phase the core builds a sine, a rising sawtooth, a falling ramp, a square wave or pseudo-random noise. A select input picks which one drives the output register. The sine comes from a quarter-wave polynomial built in logic, so there is no lookup table. A power-down input freezes the accumulator and the noise generator and forces the output to mid-scale.

Every output sample is registered. It appears two clocks after the phase, select and noise value it was built from are sampled.

Top module: `dds_core`

## Requirements
- R1: On every clock with power-down low, the accumulator becomes (accumulator + tuning word + frequency offset) modulo 2^32. The frequency offset is read as two's complement, and the accumulator is 0 after reset.
- R2: The working phase is (accumulator bits 31..20 + phase offset) modulo 4096.
- R3: Select code 1 (sawtooth) outputs working-phase bits 11..2.
- R4: Select code 2 (ramp) outputs the bitwise inverse of working-phase bits 11..2, which gives a falling slope.
- R5: Select code 3 (square) outputs 1023 when working-phase bit 11 is 0, and 0 when it is 1.
- R6: Select code 4 (noise) outputs the low 10 bits of a 16-bit LFSR. The LFSR shifts right each clock and XORs 0xB400 into the shifted value when the bit shifted out is 1. It starts at 0xACE1 after reset and is never zero.
- R7: Select code 0 (sine) gives an offset-binary sine. Let m = bits 9..0 of the working phase, inverted when bit 10 is 1, and let k = round(511·sin(π/2·(2m+1)/2048)). The output is 512+k when phase bit 11 is 0 and 511−k when it is 1, with each sample within ±3 of that value.
- R8: On a clock with power-down high, the accumulator, the LFSR and the pipeline stage hold their values, and the output becomes 512.
- R9: Select codes 5, 6 and 7 give 512. The output reflects the phase, select and LFSR value sampled two clocks earlier.
- R10: During and right after reset the output is 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down: freeze state and force mid-scale |
| ftw | input | 32 | Frequency tuning word |
| fm_ofs | input | 32 | Signed frequency-modulation offset |
| pm_ofs | input | 12 | Phase-modulation offset |
| wave_sel | input | 3 | Waveform select code |
| amp_out | output | 10 | Registered amplitude for the DAC |

## Verification
A wrong accumulator value appears two clocks later as a wrong sawtooth code. Because the error persists in the phase, every later sample stays shifted. A bad LFSR step shows up in the noise stream two clocks after it happens, and from then on the sequence never realigns. A power-down that does not hold state shows up as a phase or noise jump in the first two samples after release. A select or pipeline misalignment shows up as the wrong waveform on the two samples that follow a select change.

// File: rtl/dds_pkg.sv
package dds_pkg;

   typedef enum logic [2:0] {
      WV_SINE   = 3'd0,
      WV_SAW    = 3'd1,
      WV_RAMP   = 3'd2,
      WV_SQUARE = 3'd3,
      WV_NOISE  = 3'd4
   } wave_e;

   // Galois feedback masks for right-shifting maximal-length LFSRs
   function automatic logic [63:0] lfsr_mask(input int w);
      case (w)
         8:       lfsr_mask = 64'hB8;
         16:      lfsr_mask = 64'hB400;
         24:      lfsr_mask = 64'hE10000;
         32:      lfsr_mask = 64'hA300_0000;
         default: lfsr_mask = 64'h0;
      endcase
   endfunction

   function automatic bit lfsr_width_ok(input int w);
      lfsr_width_ok = (lfsr_mask(w) != 64'h0);
   endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int ACC_W = 32,
   parameter int PH_W  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [ACC_W-1:0] ftw,
   input  logic [ACC_W-1:0] fm_ofs,
   input  logic [PH_W-1:0]  pm_ofs,
   output logic [ACC_W-1:0] acc_q,
   output logic [PH_W-1:0]  phase
);

   logic [ACC_W-1:0] step;

   // two's complement offset adds modulo 2^ACC_W like an unsigned term
   assign step  = ftw + fm_ofs;
   assign phase = acc_q[ACC_W-1 -: PH_W] + pm_ofs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (!hold) acc_q <= acc_q + step;
   end

endmodule

// File: rtl/dds_lfsr.sv
module dds_lfsr
   import dds_pkg::*;
#(
   parameter int             W    = 16,
   parameter logic [W-1:0]   SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   output logic [W-1:0] state
);

   localparam logic [63:0] MASK64 = lfsr_mask(W);
   localparam logic [W-1:0] MASK  = MASK64[W-1:0];

   if (!lfsr_width_ok(W)) begin : g_bad_width
      $error("dds_lfsr: no feedback mask for width %0d", W);
   end
   if (SEED == '0) begin : g_bad_seed
      $error("dds_lfsr: seed must be non-zero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     state <= SEED;
      else if (!hold) state <= (state >> 1) ^ (state[0] ? MASK : '0);
   end

endmodule

// File: rtl/dds_sine_quarter.sv
module dds_sine_quarter #(
   parameter int PH_W  = 12,
   parameter int AMP_W = 10
) (
   input  logic [PH_W-1:0]  phase,
   output logic [AMP_W-1:0] amp
);

   localparam int IDX_W = PH_W - 2;        // index within a quarter
   localparam int FR    = IDX_W + 1;       // fraction bits of x
   localparam int MAGW  = AMP_W - 1;
   localparam int HALF  = (1 << MAGW) - 1;
   localparam int SH    = FR + 4;          // coefficients carry 4 extra bits
   localparam int SW    = FR + 18;
   // odd polynomial for sin(pi/2*x), scaled by HALF*16
   localparam int K1 = int'(real'(HALF) * 1.5706 * 16.0);
   localparam int K3 = int'(real'(HALF) * 0.6432 * 16.0);
   localparam int K5 = int'(real'(HALF) * 0.0724 * 16.0);

   logic [IDX_W-1:0] idx;
   logic [FR-1:0]    xi, x2, x3, x5;
   logic [2*FR-1:0]  p2, p3, p5;
   logic [SW-1:0]    pos, neg, mag_raw;
   logic [MAGW-1:0]  mag;
   logic [AMP_W-1:0] upper;

   // second quadrant of each half mirrors the first
   assign idx = phase[PH_W-2] ? ~phase[IDX_W-1:0] : phase[IDX_W-1:0];
   assign xi  = {idx, 1'b1};               // sample at bin centre

   assign p2 = (2*FR)'(xi) * (2*FR)'(xi);
   assign x2 = FR'(p2 >> FR);
   assign p3 = (2*FR)'(x2) * (2*FR)'(xi);
   assign x3 = FR'(p3 >> FR);
   assign p5 = (2*FR)'(x3) * (2*FR)'(x2);
   assign x5 = FR'(p5 >> FR);

   assign pos     = SW'(K1) * SW'(xi) + SW'(K5) * SW'(x5) + SW'(1 << (SH - 1));
   assign neg     = SW'(K3) * SW'(x3);
   assign mag_raw = (pos - neg) >> SH;
   assign mag     = (mag_raw > SW'(HALF)) ? MAGW'(HALF) : MAGW'(mag_raw);

   // offset binary: positive half above mid-scale, negative half inverted
   assign upper = {1'b1, mag};
   assign amp   = phase[PH_W-1] ? ~upper : upper;

endmodule

// File: rtl/dds_wave_gen.sv
module dds_wave_gen
   import dds_pkg::*;
#(
   parameter int PH_W   = 12,
   parameter int AMP_W  = 10,
   parameter int NZ_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [PH_W-1:0]  phase,
   input  logic [2:0]       sel,
   input  logic [NZ_W-1:0]  noise,
   output logic [AMP_W-1:0] amp_out
);

   localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

   logic [PH_W-1:0]  ph_s;
   logic [2:0]       sel_s;
   logic [AMP_W-1:0] nz_s;
   logic [AMP_W-1:0] sine_v, saw_v, mux_v;

   // stage 1: capture phase, select and noise sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_s  <= '0;
         sel_s <= WV_SINE;
         nz_s  <= '0;
      end else if (!hold) begin
         ph_s  <= phase;
         sel_s <= sel;
         nz_s  <= AMP_W'(noise);
      end
   end

   dds_sine_quarter #(.PH_W(PH_W), .AMP_W(AMP_W)) u_sine (
      .phase (ph_s),
      .amp   (sine_v)
   );

   assign saw_v = ph_s[PH_W-1 -: AMP_W];

   always_comb begin
      case (sel_s)
         WV_SINE:   mux_v = sine_v;
         WV_SAW:    mux_v = saw_v;
         WV_RAMP:   mux_v = ~saw_v;
         WV_SQUARE: mux_v = {AMP_W{~ph_s[PH_W-1]}};
         WV_NOISE:  mux_v = nz_s;
         default:   mux_v = MID;
      endcase
   end

   // stage 2: output register, mid-scale while held
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    amp_out <= MID;
      else if (hold) amp_out <= MID;
      else           amp_out <= mux_v;
   end

endmodule

// File: rtl/dds_core.sv
module dds_core #(
   parameter int                ACC_W     = 32,
   parameter int                PH_W      = 12,
   parameter int                AMP_W     = 10,
   parameter int                LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_dn,
   input  logic [ACC_W-1:0] ftw,
   input  logic [ACC_W-1:0] fm_ofs,
   input  logic [PH_W-1:0]  pm_ofs,
   input  logic [2:0]       wave_sel,
   output logic [AMP_W-1:0] amp_out
);

   if (PH_W > ACC_W) begin : g_err_ph
      $error("dds_core: phase wider than accumulator");
   end
   if (AMP_W > PH_W) begin : g_err_amp
      $error("dds_core: amplitude wider than phase");
   end
   if (PH_W < 4 || AMP_W < 2) begin : g_err_small
      $error("dds_core: phase or amplitude too narrow");
   end
   if (AMP_W > LFSR_W) begin : g_err_nz
      $error("dds_core: LFSR narrower than amplitude");
   end

   logic [ACC_W-1:0]  acc_q;
   logic [PH_W-1:0]   phase;
   logic [LFSR_W-1:0] lfsr_q;

   dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (pwr_dn),
      .ftw    (ftw),
      .fm_ofs (fm_ofs),
      .pm_ofs (pm_ofs),
      .acc_q  (acc_q),
      .phase  (phase)
   );

   dds_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (pwr_dn),
      .state (lfsr_q)
   );

   dds_wave_gen #(.PH_W(PH_W), .AMP_W(AMP_W), .NZ_W(LFSR_W)) u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (pwr_dn),
      .phase   (phase),
      .sel     (wave_sel),
      .noise   (lfsr_q),
      .amp_out (amp_out)
   );

endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk
   import dds_pkg::*;
#(
   parameter int ACC_W  = 32,
   parameter int PH_W   = 12,
   parameter int AMP_W  = 10,
   parameter int LFSR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwr_dn,
   input logic [ACC_W-1:0]  ftw,
   input logic [ACC_W-1:0]  fm_ofs,
   input logic [PH_W-1:0]   pm_ofs,
   input logic [2:0]        wave_sel,
   input logic [AMP_W-1:0]  amp_out,
   input logic [ACC_W-1:0]  acc_q,
   input logic [LFSR_W-1:0] lfsr_q
);

   localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

   logic [1:0]      cyc;
   logic [PH_W-1:0] ph_c;

   assign ph_c = acc_q[ACC_W-1 -: PH_W] + pm_ofs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   // R1
   a_r1_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc != 2'd0 && !$past(pwr_dn)) |->
         acc_q == ACC_W'($past(acc_q) + $past(ftw) + $past(fm_ofs)));

   // R8
   a_r8_pd_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc != 2'd0 && $past(pwr_dn)) |->
         (acc_q == $past(acc_q) && lfsr_q == $past(lfsr_q) && amp_out == MID));

   // R6
   a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);

   // R3
   a_r3_saw_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && !$past(pwr_dn) && !$past(pwr_dn, 2) &&
       $past(wave_sel, 2) == 3'(WV_SAW)) |->
         amp_out == $past(ph_c[PH_W-1 -: AMP_W], 2));

   // R5
   a_r5_square_level: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && !$past(pwr_dn) && !$past(pwr_dn, 2) &&
       $past(wave_sel, 2) == 3'(WV_SQUARE)) |->
         amp_out == ($past(ph_c[PH_W-1], 2) ? '0 : {AMP_W{1'b1}}));

   // R9
   a_r9_spare_codes: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && !$past(pwr_dn) && !$past(pwr_dn, 2) &&
       $past(wave_sel, 2) > 3'(WV_NOISE)) |->
         amp_out == MID);

endmodule

bind dds_core dds_core_chk #(
   .ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W), .LFSR_W(LFSR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwr_dn   (pwr_dn),
   .ftw      (ftw),
   .fm_ofs   (fm_ofs),
   .pm_ofs   (pm_ofs),
   .wave_sel (wave_sel),
   .amp_out  (amp_out),
   .acc_q    (acc_q),
   .lfsr_q   (lfsr_q)
);

// File: tb/dds_core_test.sv
module dds_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_dn = 1'b0;
   logic [31:0] ftw = '0;
   logic [31:0] fm_ofs = '0;
   logic [11:0] pm_ofs = '0;
   logic [2:0]  wave_sel = '0;
   logic [9:0]  amp_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [31:0] m_acc;
   logic [15:0] m_lfsr;
   int          q_ph[$];
   int          q_sel[$];
   int          q_nz[$];

   always #10 clk = ~clk;   // 50 MHz

   dds_core uut (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .ftw(ftw),
      .fm_ofs(fm_ofs), .pm_ofs(pm_ofs), .wave_sel(wave_sel), .amp_out(amp_out)
   );

   function automatic int sine_ref(input int p);
      int  m;
      int  k;
      real x;
      m = p % 1024;
      if ((p / 1024) % 2 == 1) m = 1023 - m;
      x = (2.0 * m + 1.0) / 2048.0;
      k = $rtoi(511.0 * $sin(3.14159265358979 / 2.0 * x) + 0.5);
      return (p >= 2048) ? 511 - k : 512 + k;
   endfunction

   function automatic int wave_ref(input int p, input int s, input int nz);
      case (s)
         0: return sine_ref(p);
         1: return p / 4;
         2: return 1023 - p / 4;
         3: return (p >= 2048) ? 0 : 1023;
         4: return nz;
         default: return 512;
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp_v, input int tol);
      n_chk++;
      if (act > exp_v + tol || act < exp_v - tol) begin
         n_bad++;
         $display("FAIL %s: amp_out=%0d expected=%0d (tol %0d) at %0t",
                  tag, act, exp_v, tol, $time);
      end
   endtask

   // one clock: advance the reference with the inputs now applied,
   // then compare the registered output after the edge
   task automatic tick(input string tag);
      int exp_v;
      int tol;
      tol = 0;
      if (pwr_dn) begin
         exp_v = 512;   // R8
      end else begin
         exp_v = wave_ref(q_ph[0], q_sel[0], q_nz[0]);
         if (q_sel[0] == 0) tol = 3;
         void'(q_ph.pop_front());
         void'(q_sel.pop_front());
         void'(q_nz.pop_front());
         q_ph.push_back(int'(12'(m_acc[31:20] + pm_ofs)));
         q_sel.push_back(int'(wave_sel));
         q_nz.push_back(int'(m_lfsr[9:0]));
         m_acc  = m_acc + ftw + fm_ofs;
         m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0000);
      end
      @(posedge clk);
      @(negedge clk);
      check(tag, int'(amp_out), exp_v, tol);
   endtask

   task automatic run(input string tag, input int n);
      for (int i = 0; i < n; i++) tick(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: amp_out=%0d expected=run complete", amp_out);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      m_acc  = '0;
      m_lfsr = 16'hACE1;
      q_ph.push_back(0);
      q_sel.push_back(0);
      q_nz.push_back(0);
      repeat (3) @(negedge clk);
      check("R10 in reset", int'(amp_out), 512, 0);
      rst_n = 1'b1;
      check("R10 after release", int'(amp_out), 512, 0);

      wave_sel = 3'd1; ftw = 32'h0123_4567;
      run("R3 sawtooth", 60);
      wave_sel = 3'd2;
      run("R4 ramp", 60);
      wave_sel = 3'd3; ftw = 32'h0800_0000;
      run("R5 square", 60);
      wave_sel = 3'd4;
      run("R6 noise", 200);
      wave_sel = 3'd0; ftw = 32'h0040_0000;
      run("R7 sine sweep", 1100);
      ftw = 32'h00C3_5001;
      run("R7 sine fast", 200);

      // frequency modulation: negative and wrapping offsets
      wave_sel = 3'd1; ftw = 32'h0200_0000; fm_ofs = 32'hFF00_0000;
      run("R1 fm negative", 50);
      fm_ofs = 32'hFE00_0000;
      run("R1 fm zero step", 20);
      fm_ofs = 32'h7FFF_FFFF; ftw = 32'h8000_0002;
      run("R1 fm wrap", 50);
      fm_ofs = '0;

      // phase modulation, wrap of the 12-bit phase
      ftw = 32'h0010_0000;
      pm_ofs = 12'h800; wave_sel = 3'd3;
      run("R2 pm square", 40);
      pm_ofs = 12'hFFF; wave_sel = 3'd1;
      run("R2 pm wrap", 40);
      pm_ofs = 12'h0;

      // select changes one clock apart exercise the two-cycle delay
      for (int s = 0; s < 8; s++) begin
         wave_sel = 3'(s);
         tick("R9 select pipeline");
      end
      wave_sel = 3'd5; run("R9 code 5", 4);
      wave_sel = 3'd6; run("R9 code 6", 4);
      wave_sel = 3'd7; run("R9 code 7", 4);

      // power-down with noise and sawtooth, then resume
      wave_sel = 3'd4;
      run("R6 noise before pd", 10);
      pwr_dn = 1'b1;
      run("R8 powered down", 20);
      pwr_dn = 1'b0;
      run("R8 noise resumes", 30);
      wave_sel = 3'd1; ftw = 32'h0345_6789;
      run("R8 saw before pd", 10);
      pwr_dn = 1'b1;
      run("R8 powered down saw", 7);
      pwr_dn = 1'b0;
      run("R8 saw resumes", 20);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule